// File: doc/BRIEF.md
# Hidden-Register DAC Host Interface

This block is the host-facing register front end of a true-colour palette DAC. It sits on a byte-wide I/O bus, and a 2-bit port select picks one of four ports: mask, read index, write index and data. In its normal state the block ignores the index and data ports and hands every access to them to an external standard palette through a passthrough strobe.

A host unlocks the hidden side by reading the mask port several times in a row. The fourth consecutive read returns an identification byte and turns on extended access. While the sequence is held at that point, a write to the mask port loads a command register, and a fifth read returns the command register. With extended access on, the index ports hold 8-bit indices, and the data port moves 16-bit clock-synthesizer registers one byte at a time.

The command register drives two decoded outputs: a pixel depth in bits per pixel, and a clock divider expressed as twice its real value.

Top module: `dac_host_regs`

## Requirements
- R1: The port select encodes 0 = mask, 1 = read index, 2 = write index, 3 = data. Each mask-port read advances an unlock count by one. Mask reads that bring the count to 1, 2 or 3 return 0x00.
- R2: The mask read that brings the count to 4 returns 0x70 on rd_data in the same cycle and turns extended access on.
- R3: The mask read that brings the count to 5 returns the command register and sets the count back to 0.
- R4: A mask write while the count is 4 loads the command register from wr_data. A mask write (other than 0xFF) while the count is below 4 leaves the command register unchanged.
- R5: A mask write of 0xFF clears the count and turns extended access off.
- R6: Any read or write of ports 1, 2 or 3 clears the count.
- R7: With extended access on, a write to port 1 or 2 loads the read index or the write index, and a read of that port returns it.
- R8: With extended access on, data writes fill the low byte first and then the high byte of the register selected by the write index. The write index increments after the high byte. Writes to an index at or above the bank depth (16) are dropped.
- R9: With extended access on, data reads return the low byte first and then the high byte of the register selected by the read index. The read index increments after the high byte. Indices at or above the bank depth read as 0x00.
- R10: A mask read resets the byte toggle, so the next data access moves a low byte.
- R11: pix_bpp decodes command bits [7:4]: 2, 3, 8, A give 15; 4, 9, E give 24; 5, 6, C give 16; 7, D give 32; every other value gives 8.
- R12: clk_div_x2 decodes command bits [7:4]: 1 gives 1; 9 gives 3; 2, 6, 7, 8, A, C give 4; 4, E give 6; every other value gives 2.
- R13: With extended access off, any access to ports 1, 2 or 3 asserts pal_strobe in the same cycle and returns 0x00. Such an access changes neither the indices nor the register bank.
- R14: After reset the command register, count, extended flag, byte toggle, both indices and every bank register are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_sel | input | 2 | Port select (0 mask, 1 read index, 2 write index, 3 data) |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Read data, valid combinationally during rd_en |
| pal_strobe | output | 1 | Access is handed to the external standard palette |
| cmd_out | output | 8 | Command register |
| pix_bpp | output | 6 | Decoded pixel depth in bits per pixel |
| clk_div_x2 | output | 3 | Decoded clock divider times two |

## Verification
The assertions check the unlock count on every cycle. On every cycle they confirm that the ID byte and the command are returned at counts 4 and 5, that the count is cleared by side-port access and by a 0xFF write, and that the command register is held on mask writes below count 4. They also check that the strobe never fires while extended access is on, that index loads take effect, and that every mask read resets the toggle. Only the bench's scenarios can show the byte order across a 16-bit register, the index advance after the high byte, the out-of-range drop, and the full command decode tables. The same holds for the fact that locked-mode accesses leave the register bank untouched.

// File: rtl/dac_pkg.sv
package dac_pkg;

    localparam logic [7:0] ID_BYTE   = 8'h70;
    localparam logic [7:0] LOCK_BYTE = 8'hFF;

    typedef enum logic [1:0] {
        PORT_MASK = 2'd0,
        PORT_RIDX = 2'd1,
        PORT_WIDX = 2'd2,
        PORT_DATA = 2'd3
    } port_e;

    function automatic logic [5:0] depth_of(input logic [3:0] mode);
        case (mode)
            4'h2, 4'h3, 4'h8, 4'hA: depth_of = 6'd15;
            4'h4, 4'h9, 4'hE:       depth_of = 6'd24;
            4'h5, 4'h6, 4'hC:       depth_of = 6'd16;
            4'h7, 4'hD:             depth_of = 6'd32;
            default:                depth_of = 6'd8;
        endcase
    endfunction

    function automatic logic [2:0] div_of(input logic [3:0] mode);
        case (mode)
            4'h1:                                div_of = 3'd1;
            4'h9:                                div_of = 3'd3;
            4'h2, 4'h6, 4'h7, 4'h8, 4'hA, 4'hC:  div_of = 3'd4;
            4'h4, 4'hE:                          div_of = 3'd6;
            default:                             div_of = 3'd2;
        endcase
    endfunction

endpackage

// File: rtl/dac_unlock_seq.sv
module dac_unlock_seq
    import dac_pkg::*;
#(
    parameter int CNT_MAX   = 5,
    parameter int UNLOCK_AT = 4,
    parameter int CW        = $clog2(CNT_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mask_rd,
    input  logic          mask_wr,
    input  logic          side_acc,
    input  logic [7:0]    wdata,
    output logic [CW-1:0] cnt,
    output logic          ext,
    output logic [7:0]    cmd,
    output logic [7:0]    mask_rdata
);

    localparam logic [CW-1:0] UNLOCK_V = CW'(UNLOCK_AT);
    localparam logic [CW-1:0] MAX_V    = CW'(CNT_MAX);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ext;
        logic [7:0]    cmd;
    } seq_t;

    seq_t st_d, st_q;
    logic [CW-1:0] nxt_cnt;

    always_comb begin
        st_d       = st_q;
        mask_rdata = 8'h00;
        nxt_cnt    = (st_q.cnt < MAX_V) ? st_q.cnt + CW'(1) : st_q.cnt;
        if (mask_rd) begin
            st_d.cnt = nxt_cnt;
            if (nxt_cnt == UNLOCK_V) begin
                mask_rdata = ID_BYTE;
                st_d.ext   = 1'b1;
            end
            if (nxt_cnt == MAX_V) begin
                mask_rdata = st_q.cmd;
                st_d.cnt   = '0;
            end
        end else if (mask_wr) begin
            if (wdata == LOCK_BYTE) begin
                st_d.cnt = '0;
                st_d.ext = 1'b0;
            end else if (st_q.cnt == UNLOCK_V) begin
                st_d.cmd = wdata;
            end
        end else if (side_acc) begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
    assign ext = st_q.ext;
    assign cmd = st_q.cmd;

endmodule

// File: rtl/dac_index_ctrl.sv
module dac_index_ctrl
    import dac_pkg::*;
#(
    parameter int IW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ext,
    input  logic [1:0]    sel,
    input  logic          rd,
    input  logic          wr,
    input  logic [7:0]    wdata,
    output logic [IW-1:0] rindex,
    output logic [IW-1:0] windex,
    output logic          tog,
    output logic          bank_we,
    output logic          bank_whi,
    output logic          bank_rhi
);

    typedef struct packed {
        logic [IW-1:0] rindex;
        logic [IW-1:0] windex;
        logic          tog;
    } idx_t;

    idx_t ix_d, ix_q;
    port_e port;

    assign port = port_e'(sel);

    always_comb begin
        ix_d     = ix_q;
        bank_we  = 1'b0;
        bank_whi = ix_q.tog;
        bank_rhi = ix_q.tog;
        if (rd && port == PORT_MASK) begin
            ix_d.tog = 1'b0;
        end else if (ext && rd) begin
            if (port == PORT_DATA) begin
                ix_d.tog = ~ix_q.tog;
                if (ix_q.tog) ix_d.rindex = ix_q.rindex + IW'(1);
            end
        end else if (ext && wr) begin
            case (port)
                PORT_RIDX: ix_d.rindex = IW'(wdata);
                PORT_WIDX: ix_d.windex = IW'(wdata);
                PORT_DATA: begin
                    bank_we  = 1'b1;
                    ix_d.tog = ~ix_q.tog;
                    if (ix_q.tog) ix_d.windex = ix_q.windex + IW'(1);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ix_q <= '0;
        else        ix_q <= ix_d;
    end

    assign rindex = ix_q.rindex;
    assign windex = ix_q.windex;
    assign tog    = ix_q.tog;

endmodule

// File: rtl/dac_synth_bank.sv
module dac_synth_bank #(
    parameter int DEPTH = 16,
    parameter int IW    = 8,
    parameter int RW    = 16,
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          whi,
    input  logic [IW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic          rhi,
    input  logic [IW-1:0] raddr,
    output logic [7:0]    rdata
);

    localparam logic [IW:0] DEPTH_L = (IW+1)'(DEPTH);

    logic [RW-1:0] mem_d [DEPTH];
    logic [RW-1:0] mem_q [DEPTH];
    logic          w_ok, r_ok;
    logic [AW-1:0] wa, ra;

    assign w_ok = ({1'b0, waddr} < DEPTH_L);
    assign r_ok = ({1'b0, raddr} < DEPTH_L);
    assign wa   = AW'(waddr);
    assign ra   = AW'(raddr);

    always_comb begin
        for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
        if (we && w_ok) begin
            if (whi) mem_d[wa][15:8] = wdata;
            else     mem_d[wa][7:0]  = wdata;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mem_q[g] <= '0;
            else        mem_q[g] <= mem_d[g];
        end
    end

    always_comb begin
        rdata = 8'h00;
        if (r_ok) rdata = rhi ? mem_q[ra][15:8] : mem_q[ra][7:0];
    end

endmodule

// File: rtl/dac_host_regs.sv
module dac_host_regs
    import dac_pkg::*;
#(
    parameter int BANK_DEPTH = 16,
    parameter int IDX_W      = 8,
    parameter int CNT_MAX    = 5,
    parameter int UNLOCK_AT  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] port_sel,
    input  logic       rd_en,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       pal_strobe,
    output logic [7:0] cmd_out,
    output logic [5:0] pix_bpp,
    output logic [2:0] clk_div_x2
);

    localparam int CW = $clog2(CNT_MAX + 1);

    port_e            port;
    logic             is_mask, side_acc;
    logic [CW-1:0]    seq_cnt;
    logic             seq_ext;
    logic [7:0]       seq_rdata;
    logic [IDX_W-1:0] rindex, windex;
    logic             idx_tog, bank_we, bank_whi, bank_rhi;
    logic [7:0]       bank_rdata;

    assign port     = port_e'(port_sel);
    assign is_mask  = (port == PORT_MASK);
    assign side_acc = (rd_en || wr_en) && !is_mask;

    dac_unlock_seq #(
        .CNT_MAX   (CNT_MAX),
        .UNLOCK_AT (UNLOCK_AT),
        .CW        (CW)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .mask_rd    (rd_en && is_mask),
        .mask_wr    (wr_en && !rd_en && is_mask),
        .side_acc   (side_acc),
        .wdata      (wr_data),
        .cnt        (seq_cnt),
        .ext        (seq_ext),
        .cmd        (cmd_out),
        .mask_rdata (seq_rdata)
    );

    dac_index_ctrl #(
        .IW (IDX_W)
    ) u_idx (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext      (seq_ext),
        .sel      (port_sel),
        .rd       (rd_en),
        .wr       (wr_en),
        .wdata    (wr_data),
        .rindex   (rindex),
        .windex   (windex),
        .tog      (idx_tog),
        .bank_we  (bank_we),
        .bank_whi (bank_whi),
        .bank_rhi (bank_rhi)
    );

    dac_synth_bank #(
        .DEPTH (BANK_DEPTH),
        .IW    (IDX_W)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bank_we),
        .whi   (bank_whi),
        .waddr (windex),
        .wdata (wr_data),
        .rhi   (bank_rhi),
        .raddr (rindex),
        .rdata (bank_rdata)
    );

    always_comb begin
        rd_data = 8'h00;
        case (port)
            PORT_MASK: rd_data = seq_rdata;
            PORT_RIDX: if (seq_ext) rd_data = 8'(rindex);
            PORT_WIDX: if (seq_ext) rd_data = 8'(windex);
            PORT_DATA: if (seq_ext) rd_data = bank_rdata;
            default: ;
        endcase
    end

    assign pal_strobe = side_acc && !seq_ext;
    assign pix_bpp    = depth_of(cmd_out[7:4]);
    assign clk_div_x2 = div_of(cmd_out[7:4]);

endmodule

// File: rtl/dac_host_regs_chk.sv
module dac_host_regs_chk #(
    parameter int CW = 3,
    parameter int IW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    port_sel,
    input logic          rd_en,
    input logic          wr_en,
    input logic [7:0]    wr_data,
    input logic [7:0]    rd_data,
    input logic          pal_strobe,
    input logic [7:0]    cmd_out,
    input logic [CW-1:0] cnt,
    input logic          ext,
    input logic          tog,
    input logic [IW-1:0] rindex,
    input logic [IW-1:0] windex
);

    AST_EARLY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && port_sel == 2'd0 && cnt < CW'(3)) |-> rd_data == 8'h00); // R1
    AST_ID_ON_FOURTH: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && port_sel == 2'd0 && cnt == CW'(3)) |-> rd_data == 8'h70); // R2
    AST_EXT_ON_FOURTH: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && port_sel == 2'd0 && cnt == CW'(3)) |=> ext); // R2
    AST_CMD_ON_FIFTH: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && port_sel == 2'd0 && cnt == CW'(4)) |-> rd_data == cmd_out); // R3
    AST_FIFTH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && port_sel == 2'd0 && cnt == CW'(4)) |=> cnt == '0); // R3
    AST_CMD_HELD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && port_sel == 2'd0 && cnt < CW'(4)) |=> $stable(cmd_out)); // R4
    AST_LOCK_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && port_sel == 2'd0 && wr_data == 8'hFF) |=> (!ext && cnt == '0)); // R5
    AST_SIDE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_en || wr_en) && port_sel != 2'd0) |=> cnt == '0); // R6
    AST_RIDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (ext && wr_en && !rd_en && port_sel == 2'd1) |=> rindex == $past(IW'(wr_data))); // R7
    AST_TOG_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && port_sel == 2'd0) |=> !tog); // R10
    AST_NO_STROBE_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        pal_strobe |-> !ext); // R13

endmodule

bind dac_host_regs dac_host_regs_chk #(.CW(CW), .IW(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .port_sel   (port_sel),
    .rd_en      (rd_en),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .pal_strobe (pal_strobe),
    .cmd_out    (cmd_out),
    .cnt        (seq_cnt),
    .ext        (seq_ext),
    .tog        (idx_tog),
    .rindex     (rindex),
    .windex     (windex)
);

// File: tb/sim_dac_host_regs.sv
`timescale 1ns/1ps
module sim_dac_host_regs;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] port_sel = 2'd0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       pal_strobe;
    logic [7:0] cmd_out;
    logic [5:0] pix_bpp;
    logic [2:0] clk_div_x2;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic last_strobe;

    always #2 clk = ~clk;

    dac_host_regs u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .port_sel   (port_sel),
        .rd_en      (rd_en),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .pal_strobe (pal_strobe),
        .cmd_out    (cmd_out),
        .pix_bpp    (pix_bpp),
        .clk_div_x2 (clk_div_x2)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_rd(input logic [1:0] s, output logic [7:0] d);
        @(negedge clk);
        port_sel = s; rd_en = 1'b1; wr_en = 1'b0;
        #1 d = rd_data; last_strobe = pal_strobe;
        @(posedge clk);
        #1 rd_en = 1'b0;
    endtask

    task automatic bus_wr(input logic [1:0] s, input logic [7:0] v);
        @(negedge clk);
        port_sel = s; wr_data = v; wr_en = 1'b1; rd_en = 1'b0;
        #1 last_strobe = pal_strobe;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    function automatic int exp_bpp(input int m);
        case (m)
            2, 3, 8, 10: return 15;
            4, 9, 14:    return 24;
            5, 6, 12:    return 16;
            7, 13:       return 32;
            default:     return 8;
        endcase
    endfunction

    function automatic int exp_div(input int m);
        case (m)
            1:                     return 1;
            9:                     return 3;
            2, 6, 7, 8, 10, 12:    return 4;
            4, 14:                 return 6;
            default:               return 2;
        endcase
    endfunction

    // clear the count, then four mask reads to reach the unlock point
    task automatic unlock();
        logic [7:0] d;
        bus_rd(2'd1, d);
        for (int i = 0; i < 4; i++) bus_rd(2'd0, d);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R14 cmd", cmd_out, 0);
        chk("R14 bpp", pix_bpp, 8);
        chk("R14 div", clk_div_x2, 2);
        bus_rd(2'd2, d);
        chk("R14 locked strobe", last_strobe, 1);
    endtask

    task automatic t_sequence();
        logic [7:0] d;
        for (int i = 1; i <= 3; i++) begin
            bus_rd(2'd0, d);
            chk("R1 early read", d, 0);
        end
        bus_rd(2'd0, d);
        chk("R2 id byte", d, 8'h70);
        bus_rd(2'd0, d);
        chk("R3 fifth returns cmd", d, 0);
        bus_rd(2'd0, d);
        chk("R3 count cleared", d, 0);
        bus_rd(2'd2, d);
        chk("R2 ext on no strobe", last_strobe, 0);
    endtask

    task automatic t_cmd();
        logic [7:0] d;
        unlock();
        bus_wr(2'd0, 8'h45);
        chk("R4 cmd loaded", cmd_out, 8'h45);
        chk("R11 bpp 24", pix_bpp, 24);
        chk("R12 div 6", clk_div_x2, 6);
        bus_rd(2'd0, d);
        chk("R3 cmd readback", d, 8'h45);
        bus_rd(2'd1, d);
        bus_rd(2'd0, d);
        bus_rd(2'd0, d);
        bus_wr(2'd0, 8'h91);
        chk("R4 write below 4 ignored", cmd_out, 8'h45);
        bus_rd(2'd0, d);
        bus_rd(2'd1, d);
        bus_rd(2'd0, d);
        chk("R6 side access clears count", d, 0);
    endtask

    task automatic t_bank();
        logic [7:0] d;
        bus_wr(2'd2, 8'h02);
        bus_rd(2'd2, d);
        chk("R7 windex readback", d, 2);
        bus_wr(2'd3, 8'hA1);
        bus_wr(2'd3, 8'hB2);
        bus_wr(2'd3, 8'hC3);
        bus_wr(2'd3, 8'hD4);
        bus_rd(2'd2, d);
        chk("R8 windex advanced", d, 4);
        bus_wr(2'd1, 8'h02);
        bus_rd(2'd1, d);
        chk("R7 rindex readback", d, 2);
        bus_rd(2'd3, d); chk("R9 reg2 lo", d, 8'hA1);
        bus_rd(2'd3, d); chk("R9 reg2 hi", d, 8'hB2);
        bus_rd(2'd3, d); chk("R9 reg3 lo", d, 8'hC3);
        bus_rd(2'd3, d); chk("R9 reg3 hi", d, 8'hD4);
        bus_rd(2'd1, d);
        chk("R9 rindex advanced", d, 4);
        bus_wr(2'd2, 8'h20);
        bus_wr(2'd3, 8'h55);
        bus_wr(2'd3, 8'h66);
        bus_rd(2'd2, d);
        chk("R8 out of range index advances", d, 8'h21);
        bus_wr(2'd1, 8'h20);
        bus_rd(2'd3, d);
        chk("R9 out of range reads zero", d, 0);
        bus_rd(2'd3, d);
    endtask

    task automatic t_toggle();
        logic [7:0] d;
        bus_wr(2'd2, 8'h05);
        bus_wr(2'd3, 8'h11);
        bus_rd(2'd0, d);
        bus_wr(2'd3, 8'h22);
        bus_wr(2'd3, 8'h33);
        bus_wr(2'd1, 8'h05);
        bus_rd(2'd3, d); chk("R10 low byte rewritten", d, 8'h22);
        bus_rd(2'd0, d);
        bus_rd(2'd3, d); chk("R10 read restarts low", d, 8'h22);
        bus_rd(2'd3, d); chk("R10 high byte", d, 8'h33);
    endtask

    task automatic t_locked();
        logic [7:0] d;
        bus_wr(2'd0, 8'hFF);
        bus_wr(2'd2, 8'h05);
        chk("R5/R13 strobe after lock", last_strobe, 1);
        bus_wr(2'd3, 8'hEE);
        chk("R13 data strobe", last_strobe, 1);
        bus_rd(2'd1, d);
        chk("R13 locked read zero", d, 0);
        unlock();
        bus_rd(2'd2, d);
        chk("R13 windex untouched", d, 6);
        bus_wr(2'd1, 8'h05);
        bus_rd(2'd3, d);
        chk("R13 bank untouched", d, 8'h22);
        bus_rd(2'd3, d);
    endtask

    task automatic t_decode();
        for (int m = 0; m < 16; m++) begin
            unlock();
            bus_wr(2'd0, 8'(m << 4));
            chk("R11 depth", pix_bpp, exp_bpp(m));
            chk("R12 divider", clk_div_x2, exp_div(m));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_sequence();
        t_cmd();
        t_bank();
        t_toggle();
        t_locked();
        t_decode();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule